// File: doc/BRIEF.md
# Shutter Setting Capture Interface

This block collects the electronic-shutter configuration for a sensor timing generator and presents it as one registered word: an on/off flag, a two-bit mode code and a 9-bit load value. The shutter pulse generator downstream consumes that word. The configuration reaches the block in one of two ways, and a format pin selects which one is used.

In parallel form, three quasi-static select pins choose one of eight presets. The load value of a preset depends on the video standard pin, which picks between 525-line and 625-line timing. In serial form, an external controller drives a strobe, a clock and a data wire. It shifts in a 12-bit frame and commits the frame by pulsing the strobe low. An enable pin overrides both forms and forces the shutter off. The serial wires are asynchronous to the block clock and pass through synchronizers. The static pins are registered once.

Top module: `shut_cfg_if`

## Requirements
- R1: After reset, `shut_on` is 0, `shut_mode` is 2'b11 (no shutter) and `shut_load` is 9'h000.
- R2: While `en_pin` is 0, the outputs are `shut_on`=0, `shut_mode`=2'b11 and `shut_load`=0, whatever the format, select, standard and serial inputs are.
- R3: With `fmt_par`=1 and `std_625`=0, the select code {sel[2:0]} chooses high-speed mode 2'b01 with these loads: 0 → 0FA, 1 → 0FC, 2 → 100, 3 → 108, 4 → 118, 5 → 137.
- R4: With `fmt_par`=1 and `std_625`=1, codes 0..5 give mode 2'b01 with these loads: 0C8, 0CA, 0CE, 0D6, 0E6, 105.
- R5: Code 6 gives flickerless mode 2'b00 with load 196 (525-line) or 149 (625-line). Code 7 gives no shutter, mode 2'b11, with load 000.
- R6: With `fmt_par`=0, a bit on `ser_dat` is captured on each rising edge of `ser_clk`. The frame order is load bit 0 first, up to load bit 8, then mode bit A, then mode bit B, then one dummy bit. After transfer, `shut_mode` = {A,B}.
- R7: The shifted frame reaches the outputs only on a high-to-low transition of `ser_stb`. Clock edges without such a transition leave the outputs unchanged.
- R8: A frame whose load field is 1FF is discarded at transfer, and the previously committed serial setting stays in place.
- R9: `shut_on` is 1 exactly when the block is enabled and the selected mode is not 2'b11. A serial no-shutter frame still passes its load value through.
- R10: A change on the static pins shows at the outputs after one rising clock edge. A strobe fall shows after SYNC_STAGES+2 rising edges.
- R11: If more than 12 bits are shifted before a strobe, only the last 12 bits count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_pin | input | 1 | Shutter enable; low forces the shutter off |
| fmt_par | input | 1 | 1 = parallel presets, 0 = serial frame |
| std_625 | input | 1 | 0 = 525-line presets, 1 = 625-line presets |
| sel | input | 3 | Parallel preset select code |
| ser_stb | input | 1 | Serial strobe; its falling edge commits the frame |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| shut_on | output | 1 | Shutter active |
| shut_mode | output | 2 | 00 flickerless, 01 high-speed, 10 low-speed, 11 none |
| shut_load | output | 9 | Load value for the pulse generator |

## Verification
Static pins are driven on a falling clock edge, and the outputs are sampled at the next falling edge, which follows exactly one rising edge. For serial frames, each wire phase is held for several clock cycles so that the synchronizers see every edge. The latency test drives the strobe low and then checks that the outputs are still unchanged after SYNC_STAGES+1 rising edges and have changed after SYNC_STAGES+2. The other serial checks sample eight edges after the strobe fall, which is past the due cycle.

// File: rtl/shut_pkg.sv
package shut_pkg;
    localparam int LOAD_W     = 9;
    localparam int MODE_W     = 2;
    localparam int SEL_W      = 3;
    localparam int FRAME_BITS = LOAD_W + MODE_W + 1;

    typedef enum logic [MODE_W-1:0] {
        MODE_FLICKER = 2'b00,
        MODE_FAST    = 2'b01,
        MODE_SLOW    = 2'b10,
        MODE_NONE    = 2'b11
    } shut_mode_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [LOAD_W-1:0] load;
    } shut_cfg_t;

    localparam shut_cfg_t CFG_OFF = '{mode: MODE_NONE, load: '0};

    // Preset table; index is the select code, std picks the line standard.
    function automatic shut_cfg_t preset_lookup(input logic [SEL_W-1:0] code,
                                                input logic std);
        shut_cfg_t c;
        c.mode = MODE_FAST;
        case (code)
            3'd0: c.load = std ? 9'h0C8 : 9'h0FA;
            3'd1: c.load = std ? 9'h0CA : 9'h0FC;
            3'd2: c.load = std ? 9'h0CE : 9'h100;
            3'd3: c.load = std ? 9'h0D6 : 9'h108;
            3'd4: c.load = std ? 9'h0E6 : 9'h118;
            3'd5: c.load = std ? 9'h105 : 9'h137;
            3'd6: begin
                c.mode = MODE_FLICKER;
                c.load = std ? 9'h149 : 9'h196;
            end
            default: c = CFG_OFF;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/shut_sync.sv
module shut_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/shut_serial.sv
module shut_serial
    import shut_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stb_s,
    input  logic      sclk_s,
    input  logic      dat_s,
    output shut_cfg_t cfg_o,
    output logic      xfer_o
);
    typedef struct packed {
        logic [FRAME_BITS-1:0] sr;
        logic                  sclk_prev;
        logic                  stb_prev;
        shut_cfg_t             cfg;
    } ser_state_t;

    ser_state_t st_d, st_q;
    logic       rise_w, fall_w, bad_w;

    always_comb begin
        st_d   = st_q;
        rise_w = sclk_s & ~st_q.sclk_prev;
        fall_w = ~stb_s & st_q.stb_prev;
        bad_w  = &st_q.sr[LOAD_W-1:0];
        xfer_o = 1'b0;
        st_d.sclk_prev = sclk_s;
        st_d.stb_prev  = stb_s;
        if (rise_w) begin
            // newest bit enters at the top, so the first bit ends at bit 0
            st_d.sr = {dat_s, st_q.sr[FRAME_BITS-1:1]};
        end
        if (fall_w && !bad_w) begin
            st_d.cfg.load = st_q.sr[LOAD_W-1:0];
            st_d.cfg.mode = {st_q.sr[LOAD_W], st_q.sr[LOAD_W+1]};
            xfer_o        = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr        <= '0;
            st_q.sclk_prev <= 1'b0;
            st_q.stb_prev  <= 1'b0;
            st_q.cfg       <= CFG_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;
endmodule

// File: rtl/shut_cfg_if.sv
module shut_cfg_if
    import shut_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_pin,
    input  logic              fmt_par,
    input  logic              std_625,
    input  logic [SEL_W-1:0]  sel,
    input  logic              ser_stb,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic              shut_on,
    output logic [MODE_W-1:0] shut_mode,
    output logic [LOAD_W-1:0] shut_load
);
    localparam int SER_WIRES = 3;

    typedef struct packed {
        logic      on;
        shut_cfg_t cfg;
    } out_state_t;

    logic [SER_WIRES-1:0] ser_raw, ser_sync;
    shut_cfg_t            ser_cfg, par_cfg;
    logic                 ser_xfer;
    out_state_t           out_d, out_q;

    assign ser_raw = {ser_stb, ser_clk, ser_dat};

    shut_sync #(.STAGES(SYNC_STAGES), .WIDTH(SER_WIRES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ser_raw),
        .sync_o  (ser_sync)
    );

    shut_serial u_serial (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_s  (ser_sync[2]),
        .sclk_s (ser_sync[1]),
        .dat_s  (ser_sync[0]),
        .cfg_o  (ser_cfg),
        .xfer_o (ser_xfer)
    );

    assign par_cfg = preset_lookup(sel, std_625);

    always_comb begin
        if (!en_pin)      out_d.cfg = CFG_OFF;
        else if (fmt_par) out_d.cfg = par_cfg;
        else              out_d.cfg = ser_cfg;
        out_d.on = en_pin && (out_d.cfg.mode != MODE_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{on: 1'b0, cfg: CFG_OFF};
        else        out_q <= out_d;
    end

    assign shut_on   = out_q.on;
    assign shut_mode = out_q.cfg.mode;
    assign shut_load = out_q.cfg.load;
endmodule

// File: rtl/shut_cfg_chk.sv
module shut_cfg_chk
    import shut_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en_pin,
    input logic              fmt_par,
    input logic [SEL_W-1:0]  sel,
    input logic              shut_on,
    input logic [MODE_W-1:0] shut_mode,
    input logic [LOAD_W-1:0] shut_load,
    input logic              xfer,
    input shut_cfg_t         ser_cfg
);
    p_enable_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_pin) |-> (!shut_on && shut_mode == 2'b11 && shut_load == '0));

    p_on_not_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shut_on |-> (shut_mode != 2'b11));

    p_no_forbidden_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shut_load != {LOAD_W{1'b1}});

    p_commit_only_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(ser_cfg));

    p_fast_presets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_pin) && $past(fmt_par) && $past(sel) < 3'd6)
        |-> (shut_mode == 2'b01 && shut_on));
endmodule

bind shut_cfg_if shut_cfg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_pin    (en_pin),
    .fmt_par   (fmt_par),
    .sel       (sel),
    .shut_on   (shut_on),
    .shut_mode (shut_mode),
    .shut_load (shut_load),
    .xfer      (ser_xfer),
    .ser_cfg   (ser_cfg)
);

// File: tb/tb_shut_cfg_if.sv
`timescale 1ns/1ps
module tb_shut_cfg_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_pin = 1'b1, fmt_par = 1'b1, std_625 = 1'b0;
    logic [2:0] sel = 3'd7;
    logic       ser_stb = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
    logic       shut_on;
    logic [1:0] shut_mode;
    logic [8:0] shut_load;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    shut_cfg_if dut (.*);

    task automatic check(input string req, input logic on_e,
                         input logic [1:0] mode_e, input logic [8:0] load_e);
        n_chk++;
        if (shut_on !== on_e || shut_mode !== mode_e || shut_load !== load_e) begin
            n_bad++;
            $display("FAIL %s: got on=%0b mode=%b load=%h, want on=%0b mode=%b load=%h",
                     req, shut_on, shut_mode, shut_load, on_e, mode_e, load_e);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b; cyc(3);
        ser_clk = 1'b1; cyc(3);
        ser_clk = 1'b0; cyc(3);
    endtask

    task automatic shift_frame(input logic [8:0] ld, input logic a, input logic b);
        for (int i = 0; i < 9; i++) send_bit(ld[i]);
        send_bit(a);
        send_bit(b);
        send_bit(1'b0);
    endtask

    task automatic strobe();
        ser_stb = 1'b0; cyc(4);
        ser_stb = 1'b1; cyc(4);
    endtask

    task automatic t_reset();
        cyc(1);
        check("R1 reset", 1'b0, 2'b11, 9'h000);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic t_parallel(input logic std);
        logic [8:0] tbl [8];
        if (!std) tbl = '{9'h0FA, 9'h0FC, 9'h100, 9'h108, 9'h118, 9'h137, 9'h196, 9'h000};
        else      tbl = '{9'h0C8, 9'h0CA, 9'h0CE, 9'h0D6, 9'h0E6, 9'h105, 9'h149, 9'h000};
        fmt_par = 1'b1; en_pin = 1'b1; std_625 = std;
        for (int c = 0; c < 8; c++) begin
            sel = 3'(c);
            cyc(1);
            if (c < 6)       check(std ? "R4 fast preset" : "R3 fast preset", 1'b1, 2'b01, tbl[c]);
            else if (c == 6) check("R5 flicker preset", 1'b1, 2'b00, tbl[c]);
            else             check("R5 off preset", 1'b0, 2'b11, 9'h000);
        end
    endtask

    task automatic t_enable_off();
        fmt_par = 1'b1; sel = 3'd2; en_pin = 1'b0;
        cyc(1);
        check("R2 disabled parallel", 1'b0, 2'b11, 9'h000);
        fmt_par = 1'b0;
        cyc(1);
        check("R2 disabled serial", 1'b0, 2'b11, 9'h000);
        en_pin = 1'b1;
        cyc(1);
    endtask

    task automatic t_serial_frames();
        fmt_par = 1'b0;
        shift_frame(9'h0A5, 1'b0, 1'b1); strobe();
        check("R6 serial fast", 1'b1, 2'b01, 9'h0A5);
        shift_frame(9'h123, 1'b1, 1'b0); strobe();
        check("R6 serial slow", 1'b1, 2'b10, 9'h123);
        shift_frame(9'h050, 1'b0, 1'b0); strobe();
        check("R6 serial flicker", 1'b1, 2'b00, 9'h050);
    endtask

    task automatic t_no_strobe();
        shift_frame(9'h1C3, 1'b1, 1'b0); cyc(8);
        check("R7 no strobe", 1'b1, 2'b00, 9'h050);
    endtask

    task automatic t_reject();
        shift_frame(9'h1FF, 1'b0, 1'b1); strobe();
        check("R8 1FF rejected", 1'b1, 2'b00, 9'h050);
    endtask

    task automatic t_serial_none();
        shift_frame(9'h077, 1'b1, 1'b1); strobe();
        check("R9 serial none", 1'b0, 2'b11, 9'h077);
    endtask

    task automatic t_overlong();
        send_bit(1'b1); send_bit(1'b1);
        shift_frame(9'h00C, 1'b0, 1'b1); strobe();
        check("R11 last 12 bits", 1'b1, 2'b01, 9'h00C);
    endtask

    task automatic t_latency();
        fmt_par = 1'b1; sel = 3'd3; std_625 = 1'b0;
        cyc(1);
        check("R10 static one edge", 1'b1, 2'b01, 9'h108);
        fmt_par = 1'b0;
        cyc(1);
        shift_frame(9'h0E1, 1'b1, 1'b0);
        ser_stb = 1'b0;
        cyc(3);
        check("R10 before due edge", 1'b1, 2'b01, 9'h00C);
        cyc(1);
        check("R10 on due edge", 1'b1, 2'b10, 9'h0E1);
        ser_stb = 1'b1; cyc(4);
    endtask

    initial begin
        t_reset();
        t_parallel(1'b0);
        t_parallel(1'b1);
        t_enable_off();
        t_serial_frames();
        t_no_strobe();
        t_reject();
        t_serial_none();
        t_overlong();
        t_latency();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule